// File: doc/BRIEF.md
# Nested-Loop Address Sequencer for Block Transfers

This block produces the byte addresses for one side of a block transfer. It walks a two-level loop. The inner loop covers the elements of a row, and the outer loop covers the rows. After each element that is not the last of its row, the inner stride is added to the address. After the last element of a row, only the outer stride is added. The inner counter then reloads and the row counter counts down. Both strides are signed byte offsets, so the address can move backwards. This allows a column-order read of an array, or a write that rotates a block by 90 degrees.

A `start` pulse samples the base address, the element size, the counts and the strides. While `valid` is high, `addr` holds the current element. A `step` pulse moves past that element. `last_row` marks the final element of each row. `done` rises once the final element has been stepped past.

The controller has three states:
- `ST_IDLE`: held after reset.
- `ST_RUN`: addresses are being issued.
- `ST_DONE`: the sequence is finished.

The transitions are:
- LOAD (`start` with a non-zero inner count): any state goes to `ST_RUN`.
- EMPTY (`start` with a zero inner count): any state goes to `ST_DONE`.
- ADVANCE_X (`step` on an element that is not last in its row): `ST_RUN` stays in `ST_RUN`.
- ADVANCE_Y (`step` on the last element of a row while more rows remain): `ST_RUN` stays in `ST_RUN`.
- FINISH (`step` on the last element of the last row): `ST_RUN` goes to `ST_DONE`.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `valid`, `done` and `last_row` are 0 and `addr` is 0.
- R2: The cycle after a `start` with a non-zero `cfg_xcount`, `valid` is 1 and `addr` equals `cfg_base` with its alignment bits cleared (see R9).
- R3: A `step` while `valid` is high on an element that is not last in its row adds `cfg_xstride` to the address, modulo 2^32.
- R4: A `step` on the last element of a row, when more rows remain, adds only `cfg_ystride` and not `cfg_xstride`. The next row again holds `cfg_xcount` elements.
- R5: A `cfg_ycount` of 0 or 1 gives a single row of `cfg_xcount` elements. A value N of 2 or more gives N rows.
- R6: `last_row` is high exactly while `valid` is high and the current element is the final element of its row.
- R7: The cycle after the `step` that consumes the final element, `done` is 1 and `valid` is 0. After that, `done` stays high and `addr` stays unchanged under further `step` pulses until the next `start`.
- R8: A `start` with `cfg_xcount` = 0 gives `done` = 1 on the next cycle, and `valid` never goes high for that transfer.
- R9: The element size code `cfg_esize` selects the element width. Code 0 is 1 byte, code 1 is 2 bytes, and codes 2 and 3 are 4 bytes. Address bit 0 (for 2 bytes) or bits 1:0 (for 4 bytes) read as 0.
- R10: A `step` while idle after reset has no effect: `valid` and `done` stay 0 and `addr` stays 0.
- R11: A `start` during a running sequence restarts it from the new configuration on the next cycle.
- R12: With byte elements, an inner count of 5 and stride of 4 combined with an outer count of 4 and stride of -15 reads a 4-wide, 5-tall array in column order. With an inner count of 4 and stride of 4 combined with an outer count of 4 and stride of -13, the sequence writes a 4x4 block rotated by 90 degrees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the configuration and begin a sequence |
| step | input | 1 | Consume the current element |
| cfg_base | input | 32 | Start byte address |
| cfg_esize | input | 2 | Element size code (0: 1 B, 1: 2 B, 2 or 3: 4 B) |
| cfg_xcount | input | 16 | Elements per row |
| cfg_xstride | input | 32 | Signed byte offset between elements in a row |
| cfg_ycount | input | 16 | Number of rows (0 means one row) |
| cfg_ystride | input | 32 | Signed byte offset from the last element of a row to the first of the next |
| addr | output | 32 | Current element address |
| valid | output | 1 | `addr` holds a live element |
| last_row | output | 1 | Current element is the final one of its row |
| done | output | 1 | Sequence finished |

## Verification
The hardest cases to reach from the ports are the edges of the counters. These are a row of a single element, where every step is a row change, and the exact step that ends the final row. A negative outer stride that carries the address below zero is equally hard to reach. The stimulus sweeps the inner count from 0 to 3 and the outer count from 0 to 3. Each count pair runs against positive and negative strides, and one base address sits next to the 32-bit boundary so that additions wrap. The expected address of every element comes from a closed-form row and column formula. This formula is independent of how the design accumulates its strides. The two array reshaping cases are checked against the element placement that a column read and a rotation require.

// File: rtl/agen_pkg.sv
package agen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } agen_state_e;
endpackage

// File: rtl/agen_cnt.sv
module agen_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         reload,
    input  logic [W-1:0] reload_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         is_one
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (reload)
            cnt <= reload_val;
        else if (dec)
            cnt <= cnt - ONE;
    end

    assign is_one = (cnt == ONE);
endmodule

// File: rtl/agen_addr.sv
module agen_addr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          add,
    input  logic [AW-1:0] delta,
    output logic [AW-1:0] acc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (load)
            acc <= base;
        else if (add)
            acc <= acc + delta;
    end
endmodule

// File: rtl/agen_fsm.sv
module agen_fsm
    import agen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        step,
    input  logic        x_empty,
    input  logic        x_one,
    input  logic        y_one,
    output agen_state_e state,
    output logic        ld,
    output logic        adv_x,
    output logic        adv_y,
    output logic        valid,
    output logic        done
);
    agen_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        ld       = 1'b0;
        adv_x    = 1'b0;
        adv_y    = 1'b0;
        if (start) begin
            ld       = 1'b1;
            state_nx = x_empty ? ST_DONE : ST_RUN;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (step) begin
                        if (!x_one)
                            adv_x = 1'b1;
                        else if (!y_one)
                            adv_y = 1'b1;
                        else
                            state_nx = ST_DONE;
                    end
                end
                ST_IDLE: state_nx = ST_IDLE;
                ST_DONE: state_nx = ST_DONE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        valid = (state == ST_RUN);
        done  = (state == ST_DONE);
    end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import agen_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          step,
    input  logic [AW-1:0] cfg_base,
    input  logic [1:0]    cfg_esize,
    input  logic [CW-1:0] cfg_xcount,
    input  logic [AW-1:0] cfg_xstride,
    input  logic [CW-1:0] cfg_ycount,
    input  logic [AW-1:0] cfg_ystride,
    output logic [AW-1:0] addr,
    output logic          valid,
    output logic          last_row,
    output logic          done
);
    localparam logic [CW-1:0] ONE_ROW = {{(CW-1){1'b0}}, 1'b1};

    agen_state_e   state;
    logic          ld, adv_x, adv_y;
    logic          x_one, y_one;
    logic [CW-1:0] xcnt, ycnt;
    logic [CW-1:0] xreload_q;
    logic [AW-1:0] xstride_q, ystride_q;
    logic [1:0]    esize_q;
    logic [AW-1:0] acc, delta, align_mask;
    logic [CW-1:0] rows_init;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xreload_q <= '0;
            xstride_q <= '0;
            ystride_q <= '0;
            esize_q   <= '0;
        end else if (ld) begin
            xreload_q <= cfg_xcount;
            xstride_q <= cfg_xstride;
            ystride_q <= cfg_ystride;
            esize_q   <= cfg_esize;
        end
    end

    assign rows_init = (cfg_ycount == '0) ? ONE_ROW : cfg_ycount;
    assign delta     = adv_y ? ystride_q : xstride_q;

    always_comb begin
        align_mask = '1;
        unique case (esize_q)
            2'd0:    align_mask = '1;
            2'd1:    align_mask[0] = 1'b0;
            default: align_mask[1:0] = 2'b00;
        endcase
    end

    agen_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .step    (step),
        .x_empty (cfg_xcount == '0),
        .x_one   (x_one),
        .y_one   (y_one),
        .state   (state),
        .ld      (ld),
        .adv_x   (adv_x),
        .adv_y   (adv_y),
        .valid   (valid),
        .done    (done)
    );

    agen_cnt #(.W(CW)) u_xcnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ld),
        .load_val   (cfg_xcount),
        .reload     (adv_y),
        .reload_val (xreload_q),
        .dec        (adv_x),
        .cnt        (xcnt),
        .is_one     (x_one)
    );

    agen_cnt #(.W(CW)) u_ycnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ld),
        .load_val   (rows_init),
        .reload     (1'b0),
        .reload_val ('0),
        .dec        (adv_y),
        .cnt        (ycnt),
        .is_one     (y_one)
    );

    agen_addr #(.AW(AW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld),
        .base  (cfg_base),
        .add   (adv_x | adv_y),
        .delta (delta),
        .acc   (acc)
    );

    assign addr     = acc & align_mask;
    assign last_row = valid & x_one;

    logic unused_ok;
    assign unused_ok = ^{xcnt, ycnt, state};
endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          step,
    input logic [CW-1:0] cfg_xcount,
    input logic [AW-1:0] addr,
    input logic          valid,
    input logic          last_row,
    input logic          done
);
    a_r7_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && done));

    a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_row |-> valid);

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(addr)));

    a_r8_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_xcount == '0) |=> (done && !valid));

    a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_xcount != '0) |=> valid);

    a_r10_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !done && !start) |=> (!valid && !done && $stable(addr)));

    a_r3_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !step && !start) |=> (valid && $stable(addr)));
endmodule

bind dma2d_addr_gen agen_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .step       (step),
    .cfg_xcount (cfg_xcount),
    .addr       (addr),
    .valid      (valid),
    .last_row   (last_row),
    .done       (done)
);

// File: tb/tb_dma2d_addr_gen.sv
`timescale 1ns/1ps
module tb_dma2d_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        step = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [1:0]  cfg_esize = '0;
    logic [15:0] cfg_xcount = '0;
    logic [31:0] cfg_xstride = '0;
    logic [15:0] cfg_ycount = '0;
    logic [31:0] cfg_ystride = '0;
    logic [31:0] addr;
    logic        valid, last_row, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dma2d_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .cfg_base(cfg_base), .cfg_esize(cfg_esize),
        .cfg_xcount(cfg_xcount), .cfg_xstride(cfg_xstride),
        .cfg_ycount(cfg_ycount), .cfg_ystride(cfg_ystride),
        .addr(addr), .valid(valid), .last_row(last_row), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=%0d exp<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] amask(input logic [1:0] es);
        if (es == 2'd0) return 32'hFFFF_FFFF;
        else if (es == 2'd1) return 32'hFFFF_FFFE;
        else return 32'hFFFF_FFFC;
    endfunction

    task automatic pulse_start(input logic [31:0] b, input logic [1:0] es, input int xc,
                               input int xs, input int yc, input int ys);
        cfg_base = b; cfg_esize = es; cfg_xcount = 16'(xc);
        cfg_xstride = 32'(xs); cfg_ycount = 16'(yc); cfg_ystride = 32'(ys);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_step();
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    // Full sequence; expected address of element (row y, col x) is
    // base + y*((xc-1)*xs + ys) + x*xs, then alignment mask (R3, R4, R9).
    task automatic run_cfg(input logic [31:0] b, input logic [1:0] es, input int xc,
                           input int xs, input int yc, input int ys);
        int rows;
        logic [31:0] e, last_e;
        pulse_start(b, es, xc, xs, yc, ys);
        if (xc == 0) begin
            chk("R8 done", {31'b0, done}, 32'd1);
            chk("R8 valid", {31'b0, valid}, 32'd0);
            return;
        end
        rows = (yc == 0) ? 1 : yc;   // R5
        last_e = '0;
        for (int y = 0; y < rows; y++) begin
            for (int x = 0; x < xc; x++) begin
                e = (b + 32'(y * ((xc - 1) * xs + ys)) + 32'(x * xs)) & amask(es);
                chk((x == 0 && y == 0) ? "R2 first addr" : "R3/R4 addr", addr, e);
                chk("R2 valid", {31'b0, valid}, 32'd1);
                chk("R6 last_row", {31'b0, last_row}, {31'b0, (x == xc - 1)});
                last_e = e;
                do_step();
            end
        end
        chk("R7 done", {31'b0, done}, 32'd1);
        chk("R7 valid low", {31'b0, valid}, 32'd0);
        do_step();
        chk("R7 done held", {31'b0, done}, 32'd1);
        chk("R7 addr stable", addr, last_e);
    endtask

    initial begin
        int xsv[3] = '{1, -2, 5};
        int ysv[2] = '{3, -7};
        @(negedge clk);
        chk("R1 valid", {31'b0, valid}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 last_row", {31'b0, last_row}, 32'd0);
        chk("R1 addr", addr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: step while idle
        do_step();
        chk("R10 valid", {31'b0, valid}, 32'd0);
        chk("R10 done", {31'b0, done}, 32'd0);
        chk("R10 addr", addr, 32'd0);

        // Sweep of counts and strides with byte elements
        for (int xc = 0; xc <= 3; xc++)
            for (int yc = 0; yc <= 3; yc++)
                for (int i = 0; i < 3; i++)
                    for (int j = 0; j < 2; j++)
                        run_cfg(32'h0000_0100, 2'd0, xc, xsv[i], yc, ysv[j]);

        // Wrap modulo 2^32 (R3, R4)
        run_cfg(32'hFFFF_FFFE, 2'd0, 3, 4, 2, -20);
        run_cfg(32'h0000_0004, 2'd0, 2, 1, 3, -9);

        // Element size alignment (R9)
        run_cfg(32'h0000_1003, 2'd1, 3, 2, 2, -6);
        run_cfg(32'h0000_1003, 2'd2, 3, 4, 2, -12);
        run_cfg(32'h0000_2007, 2'd3, 2, 16, 2, 4);

        // R12: column-order read of a 4x5 byte array
        begin
            pulse_start(32'h0000_0400, 2'd0, 5, 4, 4, -15);
            for (int k = 0; k < 20; k++) begin
                chk("R12 column read", addr, 32'h0000_0400 + 32'((k % 5) * 4 + k / 5));
                do_step();
            end
            chk("R12 column done", {31'b0, done}, 32'd1);
        end
        // R12: 90-degree rotation of a 4x4 block
        begin
            pulse_start(32'h0000_0803, 2'd0, 4, 4, 4, -13);
            for (int k = 0; k < 16; k++) begin
                chk("R12 rotate", addr, 32'h0000_0803 + 32'((k % 4) * 4 - k / 4));
                do_step();
            end
            chk("R12 rotate done", {31'b0, done}, 32'd1);
        end

        // R11: restart during a running sequence
        pulse_start(32'h0000_3000, 2'd0, 4, 1, 2, 1);
        do_step();
        do_step();
        chk("R11 mid addr", addr, 32'h0000_3002);
        pulse_start(32'h0000_5000, 2'd0, 2, 8, 0, 0);
        chk("R11 restart addr", addr, 32'h0000_5000);
        chk("R11 restart valid", {31'b0, valid}, 32'd1);
        do_step();
        chk("R11 second addr", addr, 32'h0000_5008);
        chk("R11 last_row", {31'b0, last_row}, 32'd1);
        do_step();
        chk("R11 done", {31'b0, done}, 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule